// File: doc/BRIEF.md
# Packet bus ingress for a 32-bit transmit FIFO write port

This block sits on the physical-layer side of a 32-bit packet-over-SONET style transmit bus. On every rising edge of the bus clock it looks at an enable strobe. When that strobe is high, it takes in one 32-bit word together with its packet markers: start, end, abort, a parity bit and a two-bit count of unused bytes at the tail. Each accepted word is forwarded one cycle later on a flat write stream meant for an internal FIFO. Each forwarded word carries a byte-valid mask and first, last and abort tags. A separate preempt pulse reports a packet that was cut short.

Two error pulses go to higher layers. The parity pulse reports a mismatch between the parity bit and the data word, checked with a polarity chosen by a configuration input. The data is still forwarded unchanged. The protocol pulse reports framing that breaks the bus rules. Bytes are big-endian: the earliest byte of a word is on bits 31:24. The design is parameterised by data width. The bus clock is meant to run up to 104 MHz.

Top module: `pl3_tx_ingress`

## Requirements
- R1: Driving `rst_n` low clears every output flag at once. No packet is open once the reset has been released, which takes two clock edges through the internal synchroniser.
- R2: A word is taken only on an edge where `in_en` is high, and its results appear on the outputs in the following cycle. An edge where `in_en` is low produces no `wr_valid`, no `parity_err` and no `proto_err` in the next cycle.
- R3: On an end word, `wr_bytes` bit 3 stands for data bits 31:24, down to bit 0 for bits 7:0. The count `in_mod` maps to the mask as follows: 00 gives 1111, 01 gives 1110, 10 gives 1100 and 11 gives 1000.
- R4: A word without `in_eop` always carries `wr_bytes` = 1111. If such a word has a nonzero `in_mod`, `proto_err` pulses as well.
- R5: `in_sop` opens a packet, and its word is forwarded with `wr_first`=1. Later words are forwarded with `wr_first`=0. The word with `in_eop` is forwarded with `wr_last`=1 and closes the packet.
- R6: A word with both `in_sop` and `in_eop` is forwarded as a complete packet, with `wr_first`=1 and `wr_last`=1, and leaves no packet open.
- R7: `in_err` together with `in_eop` sets `wr_abort` on that last word. `in_err` without `in_eop` sets no abort and pulses `proto_err`.
- R8: With `odd_par`=0, the expected `in_par` equals the XOR of all 32 data bits. With `odd_par`=1, it equals the inverse of that XOR. A mismatch pulses `parity_err` for one cycle. Forwarding of the word and `wr_data` are unaffected.
- R9: A word that arrives with `in_sop`=0 while no packet is open is dropped, so `wr_valid` stays 0, and `proto_err` pulses.
- R10: An `in_sop` while a packet is open pulses `wr_preempt` and `proto_err`, which closes the old packet as aborted. The new word is forwarded with `wr_first`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock; all inputs are sampled on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| odd_par | input | 1 | Parity polarity: 0 even, 1 odd |
| in_en | input | 1 | Word strobe qualifying all other bus inputs |
| in_data | input | 32 | Packet data, big-endian |
| in_sop | input | 1 | First word of a packet |
| in_eop | input | 1 | Last word of a packet |
| in_err | input | 1 | Abort marker, meaningful with in_eop |
| in_par | input | 1 | Parity bit over in_data |
| in_mod | input | 2 | Count of unused tail bytes on the end word |
| wr_valid | output | 1 | Forwarded word present |
| wr_data | output | 32 | Forwarded data |
| wr_bytes | output | 4 | Byte-valid mask, bit 3 for bits 31:24 |
| wr_first | output | 1 | Word starts a packet |
| wr_last | output | 1 | Word ends a packet |
| wr_abort | output | 1 | Packet ending on this word is aborted |
| wr_preempt | output | 1 | Previously open packet closed as aborted |
| parity_err | output | 1 | One-cycle parity mismatch pulse |
| proto_err | output | 1 | One-cycle framing violation pulse |

## Verification
The hardest state to reach from the ports is a packet that is open when a fresh start marker arrives. To get there, the stimulus first opens a packet and then sends a middle word that carries a stray abort marker. A cycle with the strobe low comes next, and only then the second start word. The preempt is therefore checked after a mix of a violation and an idle gap, not straight after the opening word. Reset is also asserted in the middle of an open packet. The next middle word is then shown to be dropped, which proves that reset cleared the open state.

// File: rtl/pl3_rx_pkg.sv
package pl3_rx_pkg;
  // Framing decision for one strobed bus word
  typedef struct packed {
    logic accept;   // word goes to the write stream
    logic first;
    logic last;
    logic abort;
    logic preempt;  // an open packet is closed as aborted
    logic proto;    // framing violation
  } pl3_verdict_t;
endpackage

// File: rtl/pl3_lane_mask.sv
module pl3_lane_mask #(
  parameter int LANES = 4,
  parameter int MOD_W = 2
) (
  input  logic             eop,
  input  logic [MOD_W-1:0] mod,
  output logic [LANES-1:0] mask
);
  // Lane i (bits 8i+7:8i) holds data when it lies at or above the unused count
  for (genvar i = 0; i < LANES; i++) begin : g_lane
    assign mask[i] = !eop || (MOD_W'(i) >= mod);
  end
endmodule

// File: rtl/pl3_parity_chk.sv
module pl3_parity_chk #(
  parameter int DATA_W = 32
) (
  input  logic [DATA_W-1:0] data,
  input  logic              par,
  input  logic              odd_sel,
  output logic              mismatch
);
  localparam int LANES = DATA_W / 8;

  logic [LANES-1:0] lane_par;

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    assign lane_par[i] = ^data[8*i +: 8];
  end

  assign mismatch = (^lane_par) ^ par ^ odd_sel;
endmodule

// File: rtl/pl3_pkt_tracker.sv
module pl3_pkt_tracker
  import pl3_rx_pkg::*;
(
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic         sop,
  input  logic         eop,
  input  logic         err,
  input  logic         mod_nz,
  output pl3_verdict_t verdict
);
  logic open_q, open_d;

  always_comb begin
    verdict = '0;
    open_d  = open_q;
    if (en) begin
      if (sop) begin
        verdict.accept  = 1'b1;
        verdict.first   = 1'b1;
        verdict.preempt = open_q;
        verdict.proto   = open_q;
        verdict.last    = eop;
        verdict.abort   = eop && err;
        open_d          = !eop;
      end else if (open_q) begin
        verdict.accept  = 1'b1;
        verdict.last    = eop;
        verdict.abort   = eop && err;
        open_d          = !eop;
      end else begin
        verdict.proto   = 1'b1;
      end
      if (!eop && (mod_nz || err)) verdict.proto = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) open_q <= 1'b0;
    else if (en) open_q <= open_d;
  end
endmodule

// File: rtl/pl3_tx_ingress.sv
module pl3_tx_ingress
  import pl3_rx_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          odd_par,
  input  logic                          in_en,
  input  logic [DATA_W-1:0]             in_data,
  input  logic                          in_sop,
  input  logic                          in_eop,
  input  logic                          in_err,
  input  logic                          in_par,
  input  logic [$clog2(DATA_W/8)-1:0]   in_mod,
  output logic                          wr_valid,
  output logic [DATA_W-1:0]             wr_data,
  output logic [DATA_W/8-1:0]           wr_bytes,
  output logic                          wr_first,
  output logic                          wr_last,
  output logic                          wr_abort,
  output logic                          wr_preempt,
  output logic                          parity_err,
  output logic                          proto_err
);
  localparam int LANES = DATA_W / 8;
  localparam int MOD_W = $clog2(LANES);

  // Reset: asserted asynchronously, released after two clock edges
  logic [1:0] rst_pipe;
  logic       rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[1];

  logic [LANES-1:0] mask_c;
  logic             par_bad_c;
  pl3_verdict_t     verdict_c;

  pl3_lane_mask #(.LANES(LANES), .MOD_W(MOD_W)) u_mask (
    .eop  (in_eop),
    .mod  (in_mod),
    .mask (mask_c)
  );

  pl3_parity_chk #(.DATA_W(DATA_W)) u_par (
    .data     (in_data),
    .par      (in_par),
    .odd_sel  (odd_par),
    .mismatch (par_bad_c)
  );

  pl3_pkt_tracker u_track (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .en      (in_en),
    .sop     (in_sop),
    .eop     (in_eop),
    .err     (in_err),
    .mod_nz  (|in_mod),
    .verdict (verdict_c)
  );

  // Output stage: next-state logic
  logic             valid_d, first_d, last_d, abort_d, pre_d, perr_d, proto_d;
  logic             load_word;

  always_comb begin
    load_word = verdict_c.accept;
    valid_d   = verdict_c.accept;
    first_d   = verdict_c.first;
    last_d    = verdict_c.last;
    abort_d   = verdict_c.abort;
    pre_d     = verdict_c.preempt;
    proto_d   = verdict_c.proto;
    perr_d    = in_en && par_bad_c;
  end

  // Output stage: registers
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      wr_valid   <= 1'b0;
      wr_first   <= 1'b0;
      wr_last    <= 1'b0;
      wr_abort   <= 1'b0;
      wr_preempt <= 1'b0;
      parity_err <= 1'b0;
      proto_err  <= 1'b0;
    end else begin
      wr_valid   <= valid_d;
      wr_first   <= first_d;
      wr_last    <= last_d;
      wr_abort   <= abort_d;
      wr_preempt <= pre_d;
      parity_err <= perr_d;
      proto_err  <= proto_d;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      wr_data  <= '0;
      wr_bytes <= '0;
    end else if (load_word) begin
      wr_data  <= in_data;
      wr_bytes <= mask_c;
    end
  end
endmodule

// File: rtl/pl3_tx_ingress_chk.sv
module pl3_tx_ingress_chk #(
  parameter int DATA_W = 32
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  odd_par,
  input logic                  in_en,
  input logic [DATA_W-1:0]     in_data,
  input logic                  in_eop,
  input logic                  in_par,
  input logic                  wr_valid,
  input logic [DATA_W/8-1:0]   wr_bytes,
  input logic                  wr_first,
  input logic                  wr_last,
  input logic                  wr_abort,
  input logic                  wr_preempt,
  input logic                  parity_err,
  input logic                  proto_err
);
  localparam int LANES = DATA_W / 8;

  assert_idle_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !in_en |=> (!wr_valid && !parity_err && !proto_err));

  assert_top_lane_R3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |-> wr_bytes[LANES-1]);

  assert_full_mid_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (in_en && !in_eop) |=> (!wr_valid || wr_bytes == {LANES{1'b1}}));

  assert_tags_need_valid_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_first || wr_last) |-> wr_valid);

  assert_abort_on_last_R7: assert property (@(posedge clk) disable iff (!rst_n)
    wr_abort |-> wr_last);

  assert_parity_flag_R8: assert property (@(posedge clk) disable iff (!rst_n)
    in_en |=> (parity_err == $past((^in_data) ^ in_par ^ odd_par)));

  assert_preempt_form_R10: assert property (@(posedge clk) disable iff (!rst_n)
    wr_preempt |-> (wr_first && proto_err));
endmodule

bind pl3_tx_ingress pl3_tx_ingress_chk #(.DATA_W(DATA_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_sync_n),
  .odd_par    (odd_par),
  .in_en      (in_en),
  .in_data    (in_data),
  .in_eop     (in_eop),
  .in_par     (in_par),
  .wr_valid   (wr_valid),
  .wr_bytes   (wr_bytes),
  .wr_first   (wr_first),
  .wr_last    (wr_last),
  .wr_abort   (wr_abort),
  .wr_preempt (wr_preempt),
  .parity_err (parity_err),
  .proto_err  (proto_err)
);

// File: tb/pl3_tx_ingress_test.sv
module pl3_tx_ingress_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        odd_par;
  logic        in_en;
  logic [31:0] in_data;
  logic        in_sop, in_eop, in_err, in_par;
  logic [1:0]  in_mod;
  logic        wr_valid;
  logic [31:0] wr_data;
  logic [3:0]  wr_bytes;
  logic        wr_first, wr_last, wr_abort, wr_preempt, parity_err, proto_err;

  int n_cmp = 0;
  int n_bad = 0;

  always #5 clk = ~clk;

  pl3_tx_ingress uut (
    .clk(clk), .rst_n(rst_n), .odd_par(odd_par), .in_en(in_en),
    .in_data(in_data), .in_sop(in_sop), .in_eop(in_eop), .in_err(in_err),
    .in_par(in_par), .in_mod(in_mod), .wr_valid(wr_valid), .wr_data(wr_data),
    .wr_bytes(wr_bytes), .wr_first(wr_first), .wr_last(wr_last),
    .wr_abort(wr_abort), .wr_preempt(wr_preempt), .parity_err(parity_err),
    .proto_err(proto_err)
  );

  typedef struct packed {
    logic [3:0]  req;
    logic        en, sop, eop, err, odd, bad_par;
    logic [1:0]  mod;
    logic [31:0] data;
    logic        x_valid;
    logic [3:0]  x_bytes;
    logic        x_first, x_last, x_abort, x_pre, x_perr, x_proto;
  } vec_t;

  localparam int NV = 15;
  // req en sop eop err odd bad mod data | valid bytes first last abort pre perr proto
  localparam vec_t VECS [NV] = '{
    '{4'd2,  1'b0,1'b1,1'b0,1'b0,1'b0,1'b0,2'd0,32'hAAAA_5555, 1'b0,4'h0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0}, // R2 strobe low
    '{4'd5,  1'b1,1'b1,1'b0,1'b0,1'b0,1'b0,2'd0,32'h1122_3344, 1'b1,4'hF,1'b1,1'b0,1'b0,1'b0,1'b0,1'b0}, // R5 open
    '{4'd4,  1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,2'd2,32'h5566_7788, 1'b1,4'hF,1'b0,1'b0,1'b0,1'b0,1'b0,1'b1}, // R4 stray count
    '{4'd3,  1'b1,1'b0,1'b1,1'b0,1'b0,1'b0,2'd1,32'h99AA_BBCC, 1'b1,4'hE,1'b0,1'b1,1'b0,1'b0,1'b0,1'b0}, // R3 count 01
    '{4'd6,  1'b1,1'b1,1'b1,1'b0,1'b0,1'b0,2'd3,32'hDEAD_BEEF, 1'b1,4'h8,1'b1,1'b1,1'b0,1'b0,1'b0,1'b0}, // R6 R3 count 11
    '{4'd7,  1'b1,1'b1,1'b1,1'b1,1'b0,1'b0,2'd2,32'h0102_0304, 1'b1,4'hC,1'b1,1'b1,1'b1,1'b0,1'b0,1'b0}, // R7 R3 count 10
    '{4'd9,  1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,2'd0,32'hCAFE_F00D, 1'b0,4'h0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b1}, // R9 orphan
    '{4'd5,  1'b1,1'b1,1'b0,1'b0,1'b0,1'b0,2'd0,32'h0F0F_0F0F, 1'b1,4'hF,1'b1,1'b0,1'b0,1'b0,1'b0,1'b0}, // R5 open
    '{4'd7,  1'b1,1'b0,1'b0,1'b1,1'b0,1'b0,2'd0,32'h1234_5678, 1'b1,4'hF,1'b0,1'b0,1'b0,1'b0,1'b0,1'b1}, // R7 err w/o end
    '{4'd2,  1'b0,1'b0,1'b1,1'b1,1'b0,1'b1,2'd0,32'hFFFF_FFFF, 1'b0,4'h0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0}, // R2 idle gap
    '{4'd10, 1'b1,1'b1,1'b0,1'b0,1'b0,1'b0,2'd0,32'h8765_4321, 1'b1,4'hF,1'b1,1'b0,1'b0,1'b1,1'b0,1'b1}, // R10 preempt
    '{4'd8,  1'b1,1'b0,1'b1,1'b0,1'b0,1'b1,2'd0,32'h0000_0001, 1'b1,4'hF,1'b0,1'b1,1'b0,1'b0,1'b1,1'b0}, // R8 even bad
    '{4'd8,  1'b1,1'b1,1'b1,1'b0,1'b1,1'b0,2'd0,32'h0000_0003, 1'b1,4'hF,1'b1,1'b1,1'b0,1'b0,1'b0,1'b0}, // R8 odd good
    '{4'd8,  1'b1,1'b1,1'b1,1'b0,1'b1,1'b1,2'd0,32'h7000_0000, 1'b1,4'hF,1'b1,1'b1,1'b0,1'b0,1'b1,1'b0}, // R8 odd bad
    '{4'd9,  1'b1,1'b0,1'b0,1'b0,1'b0,1'b1,2'd0,32'h00FF_0000, 1'b0,4'h0,1'b0,1'b0,1'b0,1'b0,1'b1,1'b1}  // R9 R8 orphan bad
  };

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic drive(input logic en, sop, eop, err, odd, bad, input logic [1:0] mod,
                       input logic [31:0] d);
    in_en = en; in_sop = sop; in_eop = eop; in_err = err; odd_par = odd;
    in_mod = mod; in_data = d;
    in_par = (^d) ^ odd ^ bad;
  endtask

  task automatic check_flags(input string tag, input logic [7:0] exp);
    check(tag, {56'd0, wr_valid, wr_first, wr_last, wr_abort, wr_preempt,
                parity_err, proto_err, 1'b0}, {56'd0, exp});
  endtask

  initial begin : watchdog
    repeat (5000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog actual=running expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin : main
    rst_n = 1'b0;
    drive(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 2'd0, 32'd0);
    repeat (3) @(negedge clk);
    // R1: outputs cleared while reset is held
    check_flags("R1 reset flags", 8'h00);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      drive(VECS[i].en, VECS[i].sop, VECS[i].eop, VECS[i].err, VECS[i].odd,
            VECS[i].bad_par, VECS[i].mod, VECS[i].data);
      @(negedge clk);
      begin
        string tag;
        tag = $sformatf("R%0d vec%0d", VECS[i].req, i);
        check({tag, " flags"},
              {57'd0, wr_valid, wr_first, wr_last, wr_abort, wr_preempt, parity_err, proto_err},
              {57'd0, VECS[i].x_valid, VECS[i].x_first, VECS[i].x_last, VECS[i].x_abort,
               VECS[i].x_pre, VECS[i].x_perr, VECS[i].x_proto});
        if (VECS[i].x_valid) begin
          check({tag, " bytes"}, {60'd0, wr_bytes}, {60'd0, VECS[i].x_bytes});
          check({tag, " data"}, {32'd0, wr_data}, {32'd0, VECS[i].data});
        end
      end
    end

    // R1: reset in the middle of an open packet
    drive(1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 2'd0, 32'hA1A2_A3A4);
    @(negedge clk);
    check_flags("R1 open before reset", 8'hC0);
    drive(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 2'd0, 32'd0);
    #2 rst_n = 1'b0;
    #1 check_flags("R1 async clear", 8'h00);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    // R1: open state gone, so a middle word is dropped (R9 behaviour)
    drive(1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 2'd0, 32'hB1B2_B3B4);
    @(negedge clk);
    check_flags("R1 open cleared", 8'h02);

    // R2: output holds nothing the cycle after an idle edge following a word
    drive(1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 2'd0, 32'h1);
    @(negedge clk);
    check_flags("R2 idle after word", 8'h00);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule